// File: doc/BRIEF.md
# Cache Write Policy Controller

This block sits beside a small direct-mapped cache and makes the policy decision for each processor access: whether a line is allocated by a fill, whether the cached copy is written, and whether a write goes out on the external bus. Two configuration bits steer it. One bit stops new allocations while leaving hits fully served and updated. The other bit picks write-back or write-through handling of stores. A whole-cache flush and single-line invalidations from external inquiry cycles are also handled.

A compact valid/dirty/tag store is built in so the policy can be checked alone. An address splits into a line index (low `IDX_W` bits) and a tag (the remaining upper bits). Each action appears as a one-cycle pulse on `fill_req` or `bus_wr`, with the line address on `mem_addr`. The external bus timing and the line data paths are outside this block.

The controller is one state machine with six states. IDLE accepts work. ACCESS reports the result of a hit, a write or a read miss that does not allocate. EVICT writes a dirty victim back. FILL allocates the line. FLUSH visits lines one per cycle. DONE invalidates the whole store.

The transitions are:
- IDLE→FLUSH when a flush is requested.
- IDLE→EVICT when a read misses, fills are allowed and the victim line is dirty.
- IDLE→FILL when the same read miss has a clean victim.
- IDLE→ACCESS for any other accepted request.
- ACCESS→IDLE.
- EVICT→FILL.
- FILL→IDLE.
- FLUSH→FLUSH until the last index, then FLUSH→DONE.
- DONE→IDLE.

Top module: `cache_policy_ctrl`

## Requirements
- R1: A read that hits (a valid line at the index with a matching tag) gives `hit`=1 in the cycle after acceptance. It raises neither `fill_req` nor `bus_wr`, whatever the value of `cfg_fill_off`.
- R2: A read miss with `cfg_fill_off`=0 and a clean or invalid victim pulses `fill_req` with `mem_addr` equal to the request address in the cycle after acceptance. The line becomes valid and clean, so the next read of that address hits.
- R3: A read miss with `cfg_fill_off`=0 and a valid dirty victim first pulses `bus_wr` with `mem_addr` = {victim tag, index}. In the next cycle it pulses `fill_req` for the request address.
- R4: With `cfg_fill_off`=1, a read miss raises neither `fill_req` nor `bus_wr` and allocates nothing, so a repeat of the read still misses.
- R5: A write that hits pulses `cache_upd` in the cycle after acceptance. This holds in both write modes and for both values of `cfg_fill_off`.
- R6: With `cfg_wback`=0 (write-through), every write pulses `bus_wr` with the request address, hit or miss, and never marks a line dirty.
- R7: With `cfg_wback`=1 (write-back), an unlocked write hit raises no `bus_wr` and marks the line dirty.
- R8: A write miss pulses `bus_wr` with the request address. It gives `cache_upd`=0 and allocates no line.
- R9: With `cfg_wback`=1, a write hit with `req_locked`=1 pulses both `cache_upd` and `bus_wr`. It does not mark the line dirty.
- R10: A `flush_req` pulse makes the controller visit indices 0 up to the last index, one per cycle, starting the cycle after the request. Each valid dirty line gives a `bus_wr` with its {tag, index} address. Then `flush_done` pulses for one cycle and every line becomes invalid.
- R11: A `snoop_valid` pulse in idle invalidates the line whose tag and index match `snoop_addr`, for either value of `cfg_fill_off`. While `snoop_valid` or `flush_req` is high, `req_ready` is 0.
- R12: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 after reset and returns to 1 once each operation completes. At most one of `fill_req`, `bus_wr` and `flush_done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fill_off | input | 1 | 1 = no new line allocations |
| cfg_wback | input | 1 | 1 = write-back, 0 = write-through |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_locked | input | 1 | Access is part of a locked sequence |
| req_addr | input | ADDR_W | Access line address |
| req_ready | output | 1 | Controller can take a request |
| flush_req | input | 1 | Request a whole-cache flush |
| snoop_valid | input | 1 | External inquiry invalidation |
| snoop_addr | input | ADDR_W | Line address to invalidate |
| hit | output | 1 | Accepted access hit the cache |
| cache_upd | output | 1 | Cached copy is written |
| fill_req | output | 1 | Line fill issued |
| bus_wr | output | 1 | External bus write issued |
| mem_addr | output | ADDR_W | Line address for fill or bus write |
| flush_done | output | 1 | Flush complete |

## Verification
All four combinations of the two configuration bits are exercised with a pseudo-random stream. The stream mixes reads, writes and locked writes over a few tags that share each index. This separates hits from misses, clean victims from dirty ones, and the write-through outcome from the write-back outcome of the same access history. Inquiry invalidations are inserted between accesses and each mode ends with a flush. The flush output therefore shows exactly which lines the earlier writes left dirty, while a stale valid bit shows up as a wrong hit on a later access.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_EVICT,
        ST_FILL,
        ST_FLUSH,
        ST_DONE
    } cpc_state_e;
endpackage

// File: rtl/cpc_tag_store.sv
module cpc_tag_store #(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [IDX_W-1:0] b_idx,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             dirty_set_en,
    input  logic [IDX_W-1:0] dirty_idx,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic             clear_all,
    output logic             a_valid,
    output logic             a_dirty,
    output logic [TAG_W-1:0] a_tag,
    output logic             b_valid,
    output logic             b_dirty,
    output logic [TAG_W-1:0] b_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_w;
    logic [LINES-1:0] dirty_w;
    logic [TAG_W-1:0] tag_w [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             v_q;
        logic             d_q;
        logic [TAG_W-1:0] t_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                t_q <= '0;
            end else if (clear_all) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
            end else begin
                if (alloc_en && alloc_idx == IDX_W'(g)) begin
                    v_q <= 1'b1;
                    d_q <= 1'b0;
                    t_q <= alloc_tag;
                end
                if (inv_en && inv_idx == IDX_W'(g)) begin
                    v_q <= 1'b0;
                    d_q <= 1'b0;
                end
                if (dirty_set_en && dirty_idx == IDX_W'(g)) begin
                    d_q <= 1'b1;
                end
            end
        end
        assign valid_w[g] = v_q;
        assign dirty_w[g] = d_q;
        assign tag_w[g]   = t_q;
    end

    assign a_valid = valid_w[a_idx];
    assign a_dirty = dirty_w[a_idx];
    assign a_tag   = tag_w[a_idx];
    assign b_valid = valid_w[b_idx];
    assign b_dirty = dirty_w[b_idx];
    assign b_tag   = tag_w[b_idx];

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (valid_w == '0 && dirty_w == '0)); // R10
endmodule

// File: rtl/cpc_policy_fsm.sv
module cpc_policy_fsm
    import cpc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_fill_off,
    input  logic                    cfg_wback,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_locked,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    flush_req,
    input  logic                    snoop_valid,
    input  logic [ADDR_W-1:0]       snoop_addr,
    input  logic                    a_valid,
    input  logic                    a_dirty,
    input  logic [ADDR_W-IDX_W-1:0] a_tag,
    input  logic                    b_valid,
    input  logic                    b_dirty,
    input  logic [ADDR_W-IDX_W-1:0] b_tag,
    output logic [IDX_W-1:0]        a_idx,
    output logic [IDX_W-1:0]        b_idx,
    output logic                    alloc_en,
    output logic [IDX_W-1:0]        alloc_idx,
    output logic [ADDR_W-IDX_W-1:0] alloc_tag,
    output logic                    dirty_set_en,
    output logic [IDX_W-1:0]        dirty_idx,
    output logic                    inv_en,
    output logic [IDX_W-1:0]        inv_idx,
    output logic                    clear_all,
    output logic                    req_ready,
    output logic                    hit,
    output logic                    cache_upd,
    output logic                    fill_req,
    output logic                    bus_wr,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    flush_done
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'((1 << IDX_W) - 1);

    cpc_state_e        state_q, state_d;
    logic              op_write, op_locked, op_hit, op_wb, op_cd;
    logic [ADDR_W-1:0] op_addr;
    logic [IDX_W-1:0]  scan_q;

    logic [IDX_W-1:0] req_idx, op_idx, snoop_idx;
    logic [TAG_W-1:0] req_tag, op_tag, snoop_tag;
    logic             lookup_hit, accept, snoop_take;

    assign req_idx   = req_addr[IDX_W-1:0];
    assign req_tag   = req_addr[ADDR_W-1:IDX_W];
    assign op_idx    = op_addr[IDX_W-1:0];
    assign op_tag    = op_addr[ADDR_W-1:IDX_W];
    assign snoop_idx = snoop_addr[IDX_W-1:0];
    assign snoop_tag = snoop_addr[ADDR_W-1:IDX_W];

    assign a_idx      = (state_q == ST_IDLE) ? req_idx : op_idx;
    assign b_idx      = (state_q == ST_FLUSH) ? scan_q : snoop_idx;
    assign lookup_hit = a_valid && (a_tag == req_tag);
    assign req_ready  = (state_q == ST_IDLE) && !flush_req && !snoop_valid;
    assign accept     = req_ready && req_valid;
    assign snoop_take = (state_q == ST_IDLE) && !flush_req && snoop_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (flush_req) begin
                    state_d = ST_FLUSH;
                end else if (accept) begin
                    if (!req_write && !lookup_hit && !cfg_fill_off)
                        state_d = (a_valid && a_dirty) ? ST_EVICT : ST_FILL;
                    else
                        state_d = ST_ACCESS;
                end
            end
            ST_ACCESS: state_d = ST_IDLE;
            ST_EVICT:  state_d = ST_FILL;
            ST_FILL:   state_d = ST_IDLE;
            ST_FLUSH:  state_d = (scan_q == LAST_IDX) ? ST_DONE : ST_FLUSH;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_write  <= 1'b0;
            op_locked <= 1'b0;
            op_hit    <= 1'b0;
            op_wb     <= 1'b0;
            op_cd     <= 1'b0;
            op_addr   <= '0;
            scan_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept && !flush_req) begin
                op_write  <= req_write;
                op_locked <= req_locked;
                op_hit    <= lookup_hit;
                op_wb     <= cfg_wback;
                op_cd     <= cfg_fill_off;
                op_addr   <= req_addr;
            end
            if (state_q == ST_FLUSH) scan_q <= scan_q + 1'b1;
            else                     scan_q <= '0;
        end
    end

    always_comb begin
        hit          = 1'b0;
        cache_upd    = 1'b0;
        fill_req     = 1'b0;
        bus_wr       = 1'b0;
        mem_addr     = '0;
        flush_done   = 1'b0;
        alloc_en     = 1'b0;
        alloc_idx    = op_idx;
        alloc_tag    = op_tag;
        dirty_set_en = 1'b0;
        dirty_idx    = op_idx;
        inv_en       = 1'b0;
        inv_idx      = snoop_idx;
        clear_all    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                inv_en = snoop_take && b_valid && (b_tag == snoop_tag);
            end
            ST_ACCESS: begin
                hit          = op_hit;
                cache_upd    = op_write && op_hit;
                bus_wr       = op_write && (!op_hit || !op_wb || op_locked);
                mem_addr     = op_addr;
                dirty_set_en = op_write && op_hit && op_wb && !op_locked;
            end
            ST_EVICT: begin
                bus_wr   = 1'b1;
                mem_addr = {a_tag, op_idx};
            end
            ST_FILL: begin
                fill_req = 1'b1;
                mem_addr = op_addr;
                alloc_en = 1'b1;
            end
            ST_FLUSH: begin
                bus_wr   = b_valid && b_dirty;
                mem_addr = {b_tag, scan_q};
            end
            ST_DONE: begin
                flush_done = 1'b1;
                clear_all  = 1'b1;
            end
            default: ;
        endcase
    end

    AST_FILL_ONLY_READ_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (!op_write && !op_hit)); // R2
    AST_EVICT_SAME_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && $past(bus_wr)) |-> (mem_addr[IDX_W-1:0] == $past(mem_addr[IDX_W-1:0]))); // R3
    AST_NO_FILL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> !op_cd); // R4
    AST_WT_ALWAYS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_upd && !bus_wr) |-> op_wb); // R6
    AST_DIRTY_ONLY_WB: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_set_en |-> (op_wb && cache_upd && !bus_wr)); // R7
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_req, bus_wr, flush_done})); // R12
endmodule

// File: rtl/cache_policy_ctrl.sv
module cache_policy_ctrl #(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fill_off,
    input  logic              cfg_wback,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_locked,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              flush_req,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              hit,
    output logic              cache_upd,
    output logic              fill_req,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              flush_done
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] a_idx, b_idx, alloc_idx, dirty_idx, inv_idx;
    logic [TAG_W-1:0] alloc_tag, a_tag, b_tag;
    logic             a_valid, a_dirty, b_valid, b_dirty;
    logic             alloc_en, dirty_set_en, inv_en, clear_all;

    cpc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(a_idx), .b_idx(b_idx),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_tag(alloc_tag),
        .dirty_set_en(dirty_set_en), .dirty_idx(dirty_idx),
        .inv_en(inv_en), .inv_idx(inv_idx), .clear_all(clear_all),
        .a_valid(a_valid), .a_dirty(a_dirty), .a_tag(a_tag),
        .b_valid(b_valid), .b_dirty(b_dirty), .b_tag(b_tag)
    );

    cpc_policy_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cfg_fill_off(cfg_fill_off), .cfg_wback(cfg_wback),
        .req_valid(req_valid), .req_write(req_write), .req_locked(req_locked),
        .req_addr(req_addr), .flush_req(flush_req),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .a_valid(a_valid), .a_dirty(a_dirty), .a_tag(a_tag),
        .b_valid(b_valid), .b_dirty(b_dirty), .b_tag(b_tag),
        .a_idx(a_idx), .b_idx(b_idx),
        .alloc_en(alloc_en), .alloc_idx(alloc_idx), .alloc_tag(alloc_tag),
        .dirty_set_en(dirty_set_en), .dirty_idx(dirty_idx),
        .inv_en(inv_en), .inv_idx(inv_idx), .clear_all(clear_all),
        .req_ready(req_ready), .hit(hit), .cache_upd(cache_upd),
        .fill_req(fill_req), .bus_wr(bus_wr), .mem_addr(mem_addr),
        .flush_done(flush_done)
    );
endmodule

// File: tb/cache_policy_ctrl_tb_top.sv
module cache_policy_ctrl_tb_top;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = 2;
    localparam int LINES  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_fill_off = 1'b0, cfg_wback = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_locked = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic flush_req = 1'b0, snoop_valid = 1'b0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic req_ready, hit, cache_upd, fill_req, bus_wr, flush_done;
    logic [ADDR_W-1:0] mem_addr;

    always #10 clk = ~clk;

    cache_policy_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fill_off(cfg_fill_off), .cfg_wback(cfg_wback),
        .req_valid(req_valid), .req_write(req_write), .req_locked(req_locked),
        .req_addr(req_addr), .req_ready(req_ready), .flush_req(flush_req),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .hit(hit),
        .cache_upd(cache_upd), .fill_req(fill_req), .bus_wr(bus_wr),
        .mem_addr(mem_addr), .flush_done(flush_done)
    );

    int errors = 0;
    int checks = 0;
    bit m_valid [LINES];
    bit m_dirty [LINES];
    int m_tag   [LINES];
    logic [15:0] lf = 16'hACE1;

    task automatic chk(string rq, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic do_access(bit w, bit lk, logic [ADDR_W-1:0] a);
        int idx = int'(a[IDX_W-1:0]);
        int t   = int'(a[ADDR_W-1:IDX_W]);
        bit h   = m_valid[idx] && (m_tag[idx] == t);
        string rq;
        @(negedge clk);
        chk("R12", int'(req_ready), 1, "ready before access");
        req_valid = 1'b1; req_write = w; req_locked = lk; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (!w && !h && !cfg_fill_off) begin
            if (m_valid[idx] && m_dirty[idx]) begin
                chk("R3", int'(bus_wr), 1, "victim write");
                chk("R3", int'(mem_addr), (m_tag[idx] << IDX_W) | idx, "victim addr");
                chk("R3", int'(fill_req), 0, "fill not before evict");
                @(negedge clk);
                rq = "R3";
            end else rq = "R2";
            chk(rq, int'(fill_req), 1, "fill pulse");
            chk(rq, int'(bus_wr), 0, "no bus write at fill");
            chk(rq, int'(mem_addr), int'(a), "fill addr");
            m_valid[idx] = 1'b1; m_dirty[idx] = 1'b0; m_tag[idx] = t;
        end else if (!w) begin
            rq = h ? "R1" : "R4";
            chk(rq, int'(hit), int'(h), "read hit flag");
            chk(rq, int'(fill_req), 0, "no fill");
            chk(rq, int'(bus_wr), 0, "no bus write on read");
        end else begin
            bit ewr = !h || !cfg_wback || lk;
            if (!h) rq = "R8";
            else if (!cfg_wback) rq = "R6";
            else if (lk) rq = "R9";
            else rq = "R7";
            chk(h ? "R5" : "R8", int'(cache_upd), int'(h), "cache update");
            chk(rq, int'(bus_wr), int'(ewr), "bus write");
            if (ewr) chk(rq, int'(mem_addr), int'(a), "bus write addr");
            chk(rq, int'(fill_req), 0, "no fill on write");
            if (h && cfg_wback && !lk) m_dirty[idx] = 1'b1;
        end
        @(negedge clk);
        chk("R12", int'(req_ready), 1, "ready after access");
        #1;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_req = 1'b1;
        #1;
        chk("R11", int'(req_ready), 0, "ready low with flush");
        @(negedge clk);
        flush_req = 1'b0;
        for (int k = 0; k < LINES; k++) begin
            bit e = m_valid[k] && m_dirty[k];
            chk("R10", int'(bus_wr), int'(e), "flush line write");
            if (e) chk("R10", int'(mem_addr), (m_tag[k] << IDX_W) | k, "flush addr");
            chk("R10", int'(flush_done), 0, "done not early");
            @(negedge clk);
        end
        chk("R10", int'(flush_done), 1, "flush done");
        for (int k = 0; k < LINES; k++) begin
            m_valid[k] = 1'b0; m_dirty[k] = 1'b0;
        end
        @(negedge clk);
        chk("R10", int'(flush_done), 0, "done one cycle");
        #1;
    endtask

    task automatic do_snoop(logic [ADDR_W-1:0] a);
        int idx = int'(a[IDX_W-1:0]);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = a;
        #1;
        chk("R11", int'(req_ready), 0, "ready low with snoop");
        @(negedge clk);
        snoop_valid = 1'b0;
        if (m_valid[idx] && m_tag[idx] == int'(a[ADDR_W-1:IDX_W])) begin
            m_valid[idx] = 1'b0; m_dirty[idx] = 1'b0;
        end
        #1;
    endtask

    function automatic logic [15:0] step(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        for (int k = 0; k < LINES; k++) begin
            m_valid[k] = 1'b0; m_dirty[k] = 1'b0; m_tag[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12", int'(req_ready), 1, "ready after reset");
        chk("R12", int'(fill_req | bus_wr | flush_done | cache_upd | hit), 0, "quiet after reset");

        // directed: dirty victim eviction in write-back mode
        cfg_wback = 1'b1;
        do_access(1'b0, 1'b0, 8'h05);
        do_access(1'b1, 1'b0, 8'h05);
        do_access(1'b0, 1'b0, 8'h09);
        do_access(1'b0, 1'b0, 8'h09);
        // directed: no allocation with fills off
        cfg_fill_off = 1'b1;
        do_access(1'b0, 1'b0, 8'h13);
        do_access(1'b0, 1'b0, 8'h13);
        do_access(1'b1, 1'b0, 8'h09);
        do_snoop(8'h09);
        do_access(1'b0, 1'b0, 8'h09);
        do_flush();

        for (int mode = 0; mode < 4; mode++) begin
            @(negedge clk);
            cfg_fill_off = mode[1];
            cfg_wback    = mode[0];
            for (int n = 0; n < 120; n++) begin
                logic [ADDR_W-1:0] a;
                logic [1:0] tsel;
                lf = step(lf); lf = step(lf); lf = step(lf);
                tsel = lf[3:2];
                a = {4'b0, tsel, lf[1:0]};
                if (n % 17 == 16) do_snoop(a);
                else if (n % 40 == 39 && mode < 2) begin
                    cfg_fill_off = ~cfg_fill_off;
                    do_access(1'b0, lf[4], a);
                    cfg_fill_off = mode[1];
                end else begin
                    unique case (lf[6:5])
                        2'd0, 2'd1: do_access(1'b0, lf[7], a);
                        2'd2:       do_access(1'b1, 1'b0, a);
                        default:    do_access(1'b1, 1'b1, a);
                    endcase
                end
            end
            do_flush();
        end
        summary();
    end
endmodule